// File: doc/BRIEF.md
# PRBS Link Pattern Generator and Checker

This block drives a 40-bit parallel word per clock into a serial transmit path and checks the words that come back on the receive side. At run time it sends one of three patterns. Two are pseudo-random sequences of length 2^7-1 and 2^23-1. The third is a fixed alternating 1010 word that exercises the link at its highest toggle rate. Serialization, line coding and the physical channel are outside the block. On the bench, or on a loopback, `rx_data` is simply the transmitted word after it has crossed the link.

A restart can come from the reset, from the `pat_restart` pulse or from a change of `pat_sel`. After a restart with a pseudo-random pattern selected, the generator sends a marker word before the sequence. The receive side hunts for that marker. It takes its reference state from the word that follows the marker and then compares every later word against its own prediction. The status output tells whether the checker is still hunting, locked with no errors, or locked with errors counted. A saturating counter accumulates the number of mismatched bits. A pulse on `inject_err` corrupts exactly one transmitted bit, so the error path can be tested end to end. `err_clear` empties the counter without breaking the lock.

Top module: `prbs_link_tester`

## Requirements
- R1: Pattern select `pat_sel` = 2'b10 sends the sequence b[n] = b[n-6] ^ b[n-7], and 2'b01 sends b[n] = b[n-18] ^ b[n-23]. At a restart, the earlier history bits are all ones. The 40 bits of a word are consecutive sequence bits, and bit 0 is the earliest.
- R2: While `pat_sel` is 2'b00, or the reserved value 2'b11, every transmitted word is 40'hAAAAAAAAAA (bit 0 = 0).
- R3: A restart event is any one of: `rst` high, `pat_restart` high, or `pat_sel` different from its value in the previous cycle. The word presented after a restart edge is all zeros. With a pseudo-random pattern selected, the next word is the marker 40'hD5D5D5D5D5, and the sequence of R1 starts on the word after the marker.
- R4: `chk_status` is 2'b00 while unsynchronised, 2'b01 while locked with a zero error count, and 2'b10 while locked with a non-zero count. The value 2'b11 never appears.
- R5: The checker captures an exact, word-aligned marker on `rx_data` and uses the next received word as its reference seed. `chk_status` leaves 2'b00 at the second clock edge after the marker is captured. With `pat_sel` at 2'b00 or 2'b11, the status stays 2'b00 whatever arrives on `rx_data`, including marker words.
- R6: Once locked, every received word adds its number of mismatching bits to `err_count`. The counter is CNT_W bits wide (24 by default) and holds at all ones instead of wrapping.
- R7: Each rising edge of `inject_err` inverts bit 0 of the next transmitted word. Holding the input high inverts no further words.
- R8: `err_clear` zeroes `err_count` at the next edge and takes priority over any addition in that cycle. The lock is kept, so the status returns to 2'b01 and later clean words add nothing.
- R9: A restart event zeroes `err_count` and returns `chk_status` to 2'b00 at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_sel | input | 2 | Pattern select: 00 alternating, 01 long sequence, 10 short sequence, 11 reserved (alternating) |
| pat_restart | input | 1 | Restarts generator and checker, clears the counter |
| err_clear | input | 1 | Zeroes the error counter, lock kept |
| inject_err | input | 1 | Rising edge inverts one transmitted bit |
| tx_data | output | 40 | Word toward the serializer |
| rx_data | input | 40 | Word received from the link |
| chk_status | output | 2 | 00 unsynchronised, 01 locked clean, 10 locked with errors |
| err_count | output | CNT_W | Saturating count of mismatched bits |

## Verification
The hardest state to reach from the ports is a full error counter. At the default width it needs millions of bit errors. The bench therefore builds the block with an 8-bit counter and then drives all 40 bits wrong for several words in a row, so the count must stop exactly at all ones. The clear-versus-add collision is also hard to hit. Random runs on both sequences toggle individual received bits and pulse the clear at random, and a directed cycle forces a clear in the same cycle as a corrupted word.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int DATA_W = 40;
    localparam int LFSR_W = 23;
    localparam int HDR_W  = 8;
    localparam logic [HDR_W-1:0] HDR_BYTE = 8'hD5;
    localparam int POP_W  = $clog2(DATA_W + 1);

    // feedback taps (delays into the bit history)
    localparam int SHORT_TAP_A = 6;
    localparam int SHORT_TAP_B = 7;
    localparam int LONG_TAP_A  = 18;
    localparam int LONG_TAP_B  = 23;

    typedef enum logic [1:0] {
        PAT_ALT   = 2'b00,
        PAT_LONG  = 2'b01,
        PAT_SHORT = 2'b10,
        PAT_RSV   = 2'b11
    } pat_sel_e;

    typedef enum logic [1:0] {
        ST_UNSYNC  = 2'b00,
        ST_LOCKED  = 2'b01,
        ST_ERRORED = 2'b10
    } link_status_e;

    typedef enum logic [1:0] {
        PH_HUNT  = 2'b00,
        PH_SEED  = 2'b01,
        PH_TRACK = 2'b10
    } chk_phase_e;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [LFSR_W-1:0] state;
    } prbs_step_t;

    function automatic logic is_prbs(input logic [1:0] sel);
        return (sel == PAT_LONG) || (sel == PAT_SHORT);
    endfunction

    function automatic logic [DATA_W-1:0] header_word();
        logic [DATA_W-1:0] w;
        for (int i = 0; i < DATA_W / HDR_W; i++) begin
            w[i*HDR_W +: HDR_W] = HDR_BYTE;
        end
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] alt_word();
        logic [DATA_W-1:0] w;
        for (int i = 0; i < DATA_W; i++) begin
            w[i] = i[0];
        end
        return w;
    endfunction

    // state[k] holds the bit emitted k+1 steps ago; advance a whole word
    function automatic prbs_step_t prbs_advance(input logic [LFSR_W-1:0] st_in,
                                                input logic [1:0] sel);
        prbs_step_t r;
        logic [LFSR_W-1:0] st;
        logic fb;
        st = st_in;
        for (int i = 0; i < DATA_W; i++) begin
            if (sel == PAT_SHORT) begin
                fb = st[SHORT_TAP_A-1] ^ st[SHORT_TAP_B-1];
            end else begin
                fb = st[LONG_TAP_A-1] ^ st[LONG_TAP_B-1];
            end
            r.word[i] = fb;
            st = {st[LFSR_W-2:0], fb};
        end
        r.state = st;
        return r;
    endfunction

    function automatic logic [LFSR_W-1:0] seed_from_word(input logic [DATA_W-1:0] w);
        logic [LFSR_W-1:0] s;
        for (int k = 0; k < LFSR_W; k++) begin
            s[k] = w[DATA_W-1-k];
        end
        return s;
    endfunction

    function automatic logic [POP_W-1:0] popcount(input logic [DATA_W-1:0] w);
        logic [POP_W-1:0] c;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = c + {{(POP_W-1){1'b0}}, w[i]};
        end
        return c;
    endfunction

endpackage

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [1:0]        sel,
    input  logic              inject,
    output logic [DATA_W-1:0] tx_word
);

    logic [LFSR_W-1:0] lfsr_q;
    logic              hdr_pend_q;
    logic              inj_d_q;
    logic [DATA_W-1:0] tx_q;
    prbs_step_t        nxt;
    logic              inj_rise;
    logic [DATA_W-1:0] flip_mask;

    assign nxt       = prbs_advance(lfsr_q, sel);
    assign inj_rise  = inject & ~inj_d_q;
    assign flip_mask = {{(DATA_W-1){1'b0}}, inj_rise};
    assign tx_word   = tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inj_d_q <= 1'b0;
        end else begin
            inj_d_q <= inject;
        end
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            lfsr_q     <= '1;
            hdr_pend_q <= 1'b1;
            tx_q       <= '0;
        end else if (!is_prbs(sel)) begin
            tx_q <= alt_word() ^ flip_mask;
        end else if (hdr_pend_q) begin
            tx_q       <= header_word() ^ flip_mask;
            hdr_pend_q <= 1'b0;
        end else begin
            tx_q   <= nxt.word ^ flip_mask;
            lfsr_q <= nxt.state;
        end
    end

    a_r3_marker_first: assert property (@(posedge clk) disable iff (rst)
        (hdr_pend_q && !restart && is_prbs(sel) && !inj_rise) |=> (tx_q == header_word()));

    a_r2_alt_word: assert property (@(posedge clk) disable iff (rst)
        (!restart && !is_prbs(sel) && !inj_rise) |=> (tx_q == alt_word()));

    a_r7_one_bit_flip: assert property (@(posedge clk) disable iff (rst)
        (!restart && !is_prbs(sel) && inj_rise) |=> ($countones(tx_q ^ alt_word()) == 1));

endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              err_nonzero,
    output logic              cmp_en,
    output logic [DATA_W-1:0] mism,
    output logic [1:0]        status
);

    chk_phase_e        phase_q;
    logic [LFSR_W-1:0] ref_q;
    prbs_step_t        pred;

    assign pred   = prbs_advance(ref_q, sel);
    assign cmp_en = (phase_q == PH_TRACK) && is_prbs(sel);
    assign mism   = cmp_en ? (rx_word ^ pred.word) : '0;

    always_comb begin
        if (!cmp_en) begin
            status = ST_UNSYNC;
        end else if (err_nonzero) begin
            status = ST_ERRORED;
        end else begin
            status = ST_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            phase_q <= PH_HUNT;
            ref_q   <= '0;
        end else if (!is_prbs(sel)) begin
            phase_q <= PH_HUNT;
        end else begin
            case (phase_q)
                PH_HUNT: begin
                    if (rx_word == header_word()) begin
                        phase_q <= PH_SEED;
                    end
                end
                PH_SEED: begin
                    ref_q   <= seed_from_word(rx_word);
                    phase_q <= PH_TRACK;
                end
                PH_TRACK: begin
                    ref_q <= pred.state;
                end
                default: phase_q <= PH_HUNT;
            endcase
        end
    end

    a_r4_status_legal: assert property (@(posedge clk) disable iff (rst)
        status != 2'b11);

    a_r5_seed_after_marker: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SEED) |-> ($past(rx_word) == header_word() && $past(phase_q) == PH_HUNT));

    a_r5_track_after_seed: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TRACK && !$past(restart)) |-> ($past(phase_q) != PH_HUNT));

endmodule

// File: rtl/err_tally.sv
module err_tally
    import prbs_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] bits,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum_w;

    assign sum_w = {1'b0, cnt_q} + (CNT_W+1)'(popcount(bits));
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (add_en) begin
            if (sum_w[CNT_W]) begin
                cnt_q <= '1;
            end else begin
                cnt_q <= sum_w[CNT_W-1:0];
            end
        end
    end

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt_q >= $past(cnt_q)));

    a_r6_hold_full: assert property (@(posedge clk) disable iff (rst)
        (!clr && (&cnt_q)) |=> (&cnt_q));

endmodule

// File: rtl/prbs_link_tester.sv
module prbs_link_tester
    import prbs_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pat_sel,
    input  logic              pat_restart,
    input  logic              err_clear,
    input  logic              inject_err,
    output logic [DATA_W-1:0] tx_data,
    input  logic [DATA_W-1:0] rx_data,
    output logic [1:0]        chk_status,
    output logic [CNT_W-1:0]  err_count
);

    logic [1:0]        sel_q;
    logic              restart;
    logic              cmp_en;
    logic [DATA_W-1:0] mism;

    always_ff @(posedge clk) begin
        sel_q <= pat_sel;
    end

    assign restart = rst | pat_restart | (pat_sel != sel_q);

    prbs_tx_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .sel     (pat_sel),
        .inject  (inject_err),
        .tx_word (tx_data)
    );

    prbs_rx_chk u_chk (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .sel         (pat_sel),
        .rx_word     (rx_data),
        .err_nonzero (err_count != '0),
        .cmp_en      (cmp_en),
        .mism        (mism),
        .status      (chk_status)
    );

    err_tally #(.CNT_W(CNT_W)) u_tally (
        .clk    (clk),
        .rst    (rst),
        .clr    (restart | err_clear),
        .add_en (cmp_en),
        .bits   (mism),
        .count  (err_count)
    );

    a_r9_restart_unsync: assert property (@(posedge clk) disable iff (rst)
        restart |=> (chk_status == ST_UNSYNC && err_count == '0));

endmodule

// File: tb/prbs_link_tester_tb.sv
module prbs_link_tester_tb;

    localparam int CW = 8;
    localparam int W  = 40;
    localparam int CAP = (1 << CW) - 1;
    localparam logic [W-1:0] HDR = {5{8'hD5}};
    localparam logic [W-1:0] ALT = {20{2'b10}};
    localparam logic [1:0] S_ALT = 2'b00, S_LONG = 2'b01, S_SHORT = 2'b10, S_RSV = 2'b11;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst, pat_restart, err_clear, inject_err;
    logic [1:0]    pat_sel;
    logic [W-1:0]  tx_data, rx_data;
    logic [1:0]    chk_status;
    logic [CW-1:0] err_count;
    logic [W-1:0]  flip_q, force_w;
    logic          force_en;

    assign rx_data = force_en ? force_w : (tx_data ^ flip_q);

    prbs_link_tester #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .pat_sel(pat_sel), .pat_restart(pat_restart),
        .err_clear(err_clear), .inject_err(inject_err), .tx_data(tx_data),
        .rx_data(rx_data), .chk_status(chk_status), .err_count(err_count)
    );

    int total = 0;
    int bad = 0;

    // reference model state
    int          k;
    logic [22:0] hist;
    logic [W-1:0] m_tx, m_inj;
    int          m_cnt;
    logic        m_injprev;
    logic [1:0]  m_sel;

    function automatic int ones(input logic [W-1:0] v);
        int c = 0;
        for (int i = 0; i < W; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic bit rand_sel(input logic [1:0] s);
        return (s == S_LONG) || (s == S_SHORT);
    endfunction

    function automatic logic [W-1:0] model_word();
        logic [W-1:0] w;
        logic nb;
        for (int i = 0; i < W; i++) begin
            nb = (m_sel == S_SHORT) ? (hist[5] ^ hist[6]) : (hist[17] ^ hist[22]);
            w[i] = nb;
            hist = {hist[21:0], nb};
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [1:0] exp_status();
        if (rand_sel(m_sel) && k >= 3) return (m_cnt != 0) ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    task automatic step(input logic [1:0] sel, input logic [W-1:0] flip,
                        input bit clr, input bit inj, input bit rs);
        int mm;
        pat_sel = sel; flip_q = flip; err_clear = clr; inject_err = inj; pat_restart = rs;
        if (rs || sel != m_sel) begin
            k = 0; hist = '1; m_cnt = 0; m_tx = '0; m_inj = '0;
            m_sel = sel;
        end else begin
            mm = (rand_sel(sel) && k >= 3) ? ones(m_inj ^ flip) : 0;
            if (clr) m_cnt = 0;
            else m_cnt = (m_cnt + mm > CAP) ? CAP : m_cnt + mm;
            k++;
            if (!rand_sel(sel)) m_tx = ALT;
            else if (k == 1) m_tx = HDR;
            else m_tx = model_word();
            m_inj = (inj && !m_injprev) ? {{(W-1){1'b0}}, 1'b1} : '0;
            m_tx = m_tx ^ m_inj;
        end
        m_injprev = inj;
        @(posedge clk);
        @(negedge clk);
        if (m_inj != '0)        check("R7 tx word", tx_data, m_tx);
        else if (!rand_sel(sel)) check("R2 tx word", tx_data, m_tx);
        else if (k <= 1)        check("R3 tx word", tx_data, m_tx);
        else                    check("R1 tx word", tx_data, m_tx);
        check("R4 status", chk_status, exp_status());
        check("R6 count", err_count, m_cnt);
    endtask

    function automatic logic [W-1:0] rand_flip();
        logic [W-1:0] f;
        f = {{(W-1){1'b0}}, 1'b1} << ($urandom % W);
        if ($urandom % 2 == 1) f = f | ({{(W-1){1'b0}}, 1'b1} << ($urandom % W));
        return f;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        logic [1:0] s;
        seed_v = $urandom(32'd2718);
        rst = 1'b1; pat_sel = S_SHORT; pat_restart = 0; err_clear = 0; inject_err = 0;
        flip_q = '0; force_en = 0; force_w = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        k = 0; hist = '1; m_cnt = 0; m_tx = '0; m_inj = '0; m_injprev = 0; m_sel = S_SHORT;
        check("R9 reset tx", tx_data, 0);
        check("R9 reset status", chk_status, 2'b00);
        check("R9 reset count", err_count, 0);
        rst = 1'b0;

        // lock timing on the short sequence
        step(S_SHORT, '0, 0, 0, 0);
        step(S_SHORT, '0, 0, 0, 0);
        check("R5 unsync before seed", chk_status, 2'b00);
        step(S_SHORT, '0, 0, 0, 0);
        check("R5 locked after seed", chk_status, 2'b01);

        // random runs on both sequences
        for (int p = 0; p < 2; p++) begin
            s = (p == 0) ? S_SHORT : S_LONG;
            step(s, '0, 0, 0, (p == 0));
            for (int n = 0; n < 400; n++) begin
                logic [W-1:0] f;
                f = '0;
                if (k >= 3 && ($urandom % 6) == 0) f = rand_flip();
                step(s, f, (($urandom % 40) == 0), 0, 0);
            end
        end

        // injection: held high for three cycles, one flip only
        step(S_SHORT, '0, 1, 0, 1);
        repeat (5) step(S_SHORT, '0, 0, 0, 0);
        repeat (3) step(S_SHORT, '0, 0, 1, 0);
        repeat (3) step(S_SHORT, '0, 0, 0, 0);
        check("R7 single injected bit counted", err_count, 1);
        check("R7 status errored", chk_status, 2'b10);

        // clear keeps the lock, wins over a same-cycle error
        step(S_SHORT, '0, 1, 0, 0);
        check("R8 cleared count", err_count, 0);
        check("R8 lock kept", chk_status, 2'b01);
        step(S_SHORT, {W{1'b1}}, 1, 0, 0);
        check("R8 clear beats add", err_count, 0);
        repeat (5) step(S_SHORT, '0, 0, 0, 0);
        check("R8 clean after clear", chk_status, 2'b01);

        // saturation with all bits wrong
        repeat (8) step(S_SHORT, {W{1'b1}}, 0, 0, 0);
        check("R6 saturated", err_count, CAP);
        step(S_SHORT, 40'h1, 0, 0, 0);
        check("R6 held at full", err_count, CAP);

        // selection change restarts and clears
        step(S_LONG, '0, 0, 0, 0);
        check("R9 sel change count", err_count, 0);
        check("R9 sel change status", chk_status, 2'b00);
        repeat (6) step(S_LONG, '0, 0, 0, 0);
        step(S_LONG, 40'h8000, 0, 0, 0);
        step(S_LONG, '0, 0, 0, 1);
        check("R9 restart pulse count", err_count, 0);
        check("R9 restart pulse status", chk_status, 2'b00);

        // alternating and reserved modes never lock, even on marker input
        force_en = 1; force_w = HDR;
        repeat (20) step(S_ALT, '0, 0, 0, 0);
        check("R5 alternating never locks", chk_status, 2'b00);
        repeat (10) step(S_RSV, '0, 0, 0, 0);
        check("R5 reserved never locks", chk_status, 2'b00);
        step(S_RSV, '0, 0, 1, 0);
        check("R2 alternating with one flip", tx_data, ALT ^ 40'h1);
        force_en = 0;
        step(S_RSV, '0, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule